// File: doc/BRIEF.md
# Autovectored Secondary Interrupt Controller

This block gathers 64 level-type interrupt request lines and presents them to a processor core as a single 3-bit request level. Each source has its own 4-bit priority field. A field value from 1 to 7 sets the level that the source raises. Any other value keeps the source silent. The request output always shows the highest level among the sources that are asserted and enabled.

When the core acknowledges a level, the block answers one clock later with a vector number. The vector is a programmable 8-bit base plus the index of the winning source. When nothing is pending at the acknowledged level, the answer is a programmable spurious vector instead. No vector is stored per source.

Software reaches the priority fields and the two vector registers over a small byte-addressed register bus. The bus has a write enable, a read enable and byte strobes.

Top module: `sec_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all priority fields, the base-vector register and the spurious-vector register are 0. The request level `irq_lvl` is 0 and `ack_valid` is 0.
- R2: The field of source n sits in the 32-bit word at byte offset 0x140 + 4*(n/8), at data bits [4*(n%8)+3 : 4*(n%8)]. All 32 bits of the eight words read back as written.
- R3: On a write, strobe bit `reg_be[j]` enables data byte `reg_wdata[8j+7:8j]`. Bytes whose strobe is clear keep their old value.
- R4: The spurious vector occupies bits 7:0 of the word at 0x164 (byte offset 0x167). The base vector occupies bits 7:0 of the word at 0x168 (byte offset 0x16B). Both are written through `reg_be[0]`, and the other bits of these words read as zero.
- R5: A read (`reg_rd`) returns data on `reg_rdata` one clock later, and that value holds until the next read. The low two address bits are ignored. Offsets outside the mapped words read as zero, and writes to them change no register.
- R6: `irq_lvl` is registered. One clock after the inputs change, it equals the highest level L among asserted sources whose field equals L (1 to 7), or 0 when there is none.
- R7: A source whose field is 0 or 8 to 15 never contributes to `irq_lvl` and is never selected by an acknowledge.
- R8: An `ack_stb` at level L produces a one-cycle `ack_valid` pulse in the next clock. With it comes `ack_vec` = base + n, where n is the lowest-numbered source that was asserted with field L at the strobe edge.
- R9: If no source matches at the strobe edge (including L = 0), `ack_vec` carries the spurious-vector register.
- R10: The vector sum wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 9 | Byte address within the block |
| reg_be | input | 4 | Byte strobes for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one clock after `reg_rd` |
| irq_src | input | 64 | Interrupt request lines, one per source |
| irq_lvl | output | 3 | Highest pending level, 0 = none |
| ack_stb | input | 1 | Acknowledge strobe from the core |
| ack_lvl | input | 3 | Level being acknowledged |
| ack_valid | output | 1 | One-cycle pulse marking a returned vector |
| ack_vec | output | 8 | Returned vector number |

## Verification
Every result has a latency of one clock, measured from the rising edge that samples the stimulus:
- register writes take effect at that edge;
- `reg_rdata`, `irq_lvl` and the `ack_valid`/`ack_vec` pair are all registered at that same edge.

The bench drives inputs on the falling edge and samples on the next falling edge, which is half a clock after the single register stage. It never samples in the cycle that carries the stimulus. The sources are held steady across each acknowledge, so the expected vector depends only on the state at the strobe edge. One further falling edge later, the bench confirms that `ack_valid` has dropped.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int NUM_SRC = 64;
    localparam int LVL_W   = 4;
    localparam int REQ_W   = 3;
    localparam int VEC_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 9;

    localparam logic [ADDR_W-1:0] PRIO_OFS = 9'h140;
    localparam logic [ADDR_W-1:0] SPUR_OFS = 9'h164;
    localparam logic [ADDR_W-1:0] BASE_OFS = 9'h168;

    typedef enum logic [1:0] {
        RSEL_NONE,
        RSEL_PRIO,
        RSEL_SPUR,
        RSEL_BASE
    } rsel_e;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [VEC_W-1:0] vec;
    } ack_rsp_t;

endpackage

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int N_SRC  = NUM_SRC,
    parameter int FLD_W  = LVL_W,
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int VW     = VEC_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [AW-1:0]         addr,
    input  logic [DW/8-1:0]       be,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic [N_SRC*FLD_W-1:0] prio_flat,
    output logic [VW-1:0]         base_q,
    output logic [VW-1:0]         spur_q
);

    localparam int FPW    = DW / FLD_W;
    localparam int NW     = N_SRC / FPW;
    localparam int NB     = DW / 8;
    localparam int WIDX_W = (NW > 1) ? $clog2(NW) : 1;

    logic [DW-1:0]     prio_q [NW];
    logic [AW-1:0]     word_addr;
    logic [WIDX_W-1:0] widx;
    logic              is_prio;
    rsel_e             rsel;

    assign word_addr = addr & ~AW'(3);
    assign is_prio   = (word_addr >= AW'(PRIO_OFS)) &&
                       (word_addr <  AW'(PRIO_OFS) + AW'(4 * NW));
    assign widx      = WIDX_W'((word_addr - AW'(PRIO_OFS)) >> 2);

    always_comb begin
        if (is_prio)                          rsel = RSEL_PRIO;
        else if (word_addr == AW'(SPUR_OFS))  rsel = RSEL_SPUR;
        else if (word_addr == AW'(BASE_OFS))  rsel = RSEL_BASE;
        else                                  rsel = RSEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NW; w++) prio_q[w] <= '0;
            base_q <= '0;
            spur_q <= '0;
        end else if (wr) begin
            if (rsel == RSEL_PRIO) begin
                for (int b = 0; b < NB; b++)
                    if (be[b]) prio_q[widx][8*b +: 8] <= wdata[8*b +: 8];
            end
            if (rsel == RSEL_SPUR && be[0]) spur_q <= wdata[VW-1:0];
            if (rsel == RSEL_BASE && be[0]) base_q <= wdata[VW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            unique case (rsel)
                RSEL_PRIO: rdata <= prio_q[widx];
                RSEL_SPUR: rdata <= {(DW-VW)'(0), spur_q};
                RSEL_BASE: rdata <= {(DW-VW)'(0), base_q};
                default:   rdata <= '0;
            endcase
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_flat
        assign prio_flat[w*DW +: DW] = prio_q[w];
    end

    AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> prio_flat == $past(prio_flat)); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && rsel == RSEL_NONE) |=> rdata == '0); // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata)); // R5

endmodule

// File: rtl/sic_lvl_map.sv
module sic_lvl_map
    import sic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int FLD_W = LVL_W,
    parameter int RW    = REQ_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_SRC-1:0]            irq_src,
    input  logic [N_SRC*FLD_W-1:0]      prio_flat,
    output logic [(1<<RW)*N_SRC-1:0]    hit_flat,
    output logic [RW-1:0]               irq_lvl
);

    localparam int NUM_LVL = 1 << RW;

    logic [NUM_LVL-1:0] lvl_any;
    logic [RW-1:0]      top_lvl;

    assign hit_flat[N_SRC-1:0] = '0;

    for (genvar n = 0; n < N_SRC; n++) begin : g_src
        for (genvar l = 1; l < NUM_LVL; l++) begin : g_lvl
            assign hit_flat[l*N_SRC + n] =
                irq_src[n] && (prio_flat[n*FLD_W +: FLD_W] == FLD_W'(l));
        end
    end

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_any
        assign lvl_any[l] = |hit_flat[l*N_SRC +: N_SRC];
    end

    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++)
            if (lvl_any[l]) top_lvl = RW'(l);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_lvl <= '0;
        else     irq_lvl <= top_lvl;
    end

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !(|irq_src) |=> irq_lvl == '0); // R6

    AST_REQ_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
        (irq_lvl != '0) |-> $past(|irq_src)); // R6

endmodule

// File: rtl/sic_ack.sv
module sic_ack
    import sic_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int RW    = REQ_W,
    parameter int VW    = VEC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ack_stb,
    input  logic [RW-1:0]            ack_lvl,
    input  logic [(1<<RW)*N_SRC-1:0] hit_flat,
    input  logic [VW-1:0]            base_q,
    input  logic [VW-1:0]            spur_q,
    output logic                     ack_valid,
    output logic [VW-1:0]            ack_vec
);

    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] row;
    logic             found;
    logic [IDX_W-1:0] idx;
    ack_rsp_t         rsp_d, rsp_q;

    assign row = hit_flat[ack_lvl*N_SRC +: N_SRC];

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (row[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        rsp_d.valid = ack_stb;
        rsp_d.hit   = found;
        rsp_d.vec   = found ? VW'(base_q + VW'(idx)) : spur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign ack_valid = rsp_q.valid;
    assign ack_vec   = rsp_q.vec;

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        ack_stb |=> ack_valid); // R8

    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ack_stb |=> !ack_valid); // R8

    AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && rsp_q.hit) |-> (VW'(ack_vec - $past(base_q)) < N_SRC)); // R10

    AST_SPUR_RET: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !rsp_q.hit) |-> ack_vec == $past(spur_q)); // R9

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
    import sic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W/8-1:0] reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0]  irq_src,
    output logic [REQ_W-1:0]    irq_lvl,
    input  logic                ack_stb,
    input  logic [REQ_W-1:0]    ack_lvl,
    output logic                ack_valid,
    output logic [VEC_W-1:0]    ack_vec
);

    localparam int NUM_LVL = 1 << REQ_W;

    logic [NUM_SRC*LVL_W-1:0]   prio_flat;
    logic [VEC_W-1:0]           base_q;
    logic [VEC_W-1:0]           spur_q;
    logic [NUM_LVL*NUM_SRC-1:0] hit_flat;

    sic_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .be        (reg_be),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .prio_flat (prio_flat),
        .base_q    (base_q),
        .spur_q    (spur_q)
    );

    sic_lvl_map u_map (
        .clk       (clk),
        .rst       (rst),
        .irq_src   (irq_src),
        .prio_flat (prio_flat),
        .hit_flat  (hit_flat),
        .irq_lvl   (irq_lvl)
    );

    sic_ack u_ack (
        .clk       (clk),
        .rst       (rst),
        .ack_stb   (ack_stb),
        .ack_lvl   (ack_lvl),
        .hit_flat  (hit_flat),
        .base_q    (base_q),
        .spur_q    (spur_q),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vec)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (irq_lvl == '0 && !ack_valid)); // R1

endmodule

// File: tb/sim_sec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_sec_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] irq_src = '0;
    logic [2:0]  irq_lvl;
    logic        ack_stb = 1'b0;
    logic [2:0]  ack_lvl = '0;
    logic        ack_valid;
    logic [7:0]  ack_vec;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] m_word [8];
    logic [7:0]  m_base;
    logic [7:0]  m_spur;

    always #4 clk = ~clk;

    sec_irq_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_src(irq_src), .irq_lvl(irq_lvl),
        .ack_stb(ack_stb), .ack_lvl(ack_lvl), .ack_valid(ack_valid),
        .ack_vec(ack_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] m_prio(input int n);
        return m_word[n/8][4*(n%8) +: 4];
    endfunction

    function automatic logic [2:0] exp_lvl(input logic [63:0] s);
        logic [2:0] best = 3'd0;
        for (int n = 0; n < 64; n++)
            if (s[n] && m_prio(n) >= 4'd1 && m_prio(n) <= 4'd7 && m_prio(n)[2:0] > best)
                best = m_prio(n)[2:0];
        return best;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [63:0] s, input logic [2:0] l);
        if (l != 3'd0)
            for (int n = 0; n < 64; n++)
                if (s[n] && m_prio(n) == {1'b0, l}) return 8'((int'(m_base) + n) % 256);
        return m_spur;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [8:0] a);
        logic [8:0] w = a & ~9'd3;
        if (w >= 9'h140 && w <= 9'h15C) return m_word[(w - 9'h140) >> 2];
        if (w == 9'h164) return {24'd0, m_spur};
        if (w == 9'h168) return {24'd0, m_base};
        return 32'd0;
    endfunction

    task automatic bus_wr(input logic [8:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [8:0] w = a & ~9'd3;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (w >= 9'h140 && w <= 9'h15C) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) m_word[(w - 9'h140) >> 2][8*b +: 8] = d[8*b +: 8];
        end
        if (w == 9'h164 && be[0]) m_spur = d[7:0];
        if (w == 9'h168 && be[0]) m_base = d[7:0];
    endtask

    task automatic bus_rd_chk(input string req, input logic [8:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, reg_rdata, exp_rd(a));
    endtask

    task automatic set_src_chk(input string req, input logic [63:0] v);
        @(negedge clk);
        irq_src = v;
        @(negedge clk);
        check(req, {29'd0, irq_lvl}, {29'd0, exp_lvl(v)});
    endtask

    task automatic ack_chk(input string req, input logic [2:0] l);
        @(negedge clk);
        ack_stb = 1'b1; ack_lvl = l;
        @(negedge clk);
        ack_stb = 1'b0;
        check({req, " valid"}, {31'd0, ack_valid}, 32'd1);
        check({req, " vec"}, {24'd0, ack_vec}, {24'd0, exp_vec(irq_src, l)});
    endtask

    function automatic logic [63:0] lfsr(input logic [63:0] x);
        return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
    endfunction

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] r;
        logic [31:0] wv;
        for (int i = 0; i < 8; i++) m_word[i] = '0;
        m_base = '0; m_spur = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq_lvl", {29'd0, irq_lvl}, 32'd0);
        check("R1 ack_valid", {31'd0, ack_valid}, 32'd0);
        for (int i = 0; i < 8; i++) bus_rd_chk("R1 prio reset", 9'(9'h140 + 4*i));
        bus_rd_chk("R1 spur reset", 9'h167);
        bus_rd_chk("R1 base reset", 9'h16B);

        // R2: full-word writes and read back
        for (int i = 0; i < 8; i++)
            bus_wr(9'(9'h140 + 4*i), 4'hF, 32'h8765_4321 + 32'h1111_1111 * i);
        for (int i = 0; i < 8; i++) bus_rd_chk("R2 prio readback", 9'(9'h140 + 4*i));

        // R3: byte strobes
        bus_wr(9'h144, 4'b0101, 32'hFFFF_FFFF);
        bus_rd_chk("R3 partial strobes", 9'h144);
        bus_wr(9'h148, 4'b0000, 32'h0000_0000);
        bus_rd_chk("R3 no strobes", 9'h148);
        bus_wr(9'h14E, 4'b1000, 32'hA5A5_A5A5);
        bus_rd_chk("R3 unaligned addr", 9'h14C);

        // R4: vector registers
        bus_wr(9'h16B, 4'hF, 32'hAABB_CCDD);
        bus_rd_chk("R4 base", 9'h168);
        bus_wr(9'h167, 4'b1110, 32'h1122_3344);
        bus_rd_chk("R4 spur strobe off", 9'h164);
        bus_wr(9'h167, 4'b0001, 32'h1122_3344);
        bus_rd_chk("R4 spur", 9'h167);

        // R5: unmapped offsets
        bus_wr(9'h100, 4'hF, 32'hFFFF_FFFF);
        bus_wr(9'h16C, 4'hF, 32'hFFFF_FFFF);
        bus_rd_chk("R5 unmapped 0x100", 9'h100);
        bus_rd_chk("R5 unmapped 0x13C", 9'h13C);
        bus_rd_chk("R5 unmapped 0x160", 9'h160);
        bus_rd_chk("R5 unmapped 0x16C", 9'h16C);
        for (int i = 0; i < 8; i++) bus_rd_chk("R5 prio untouched", 9'(9'h140 + 4*i));

        // Sweep setup: source n at level (n%7)+1, base 0xF0, spurious 0x5A
        for (int i = 0; i < 8; i++) begin
            wv = '0;
            for (int k = 0; k < 8; k++) wv[4*k +: 4] = 4'(((8*i + k) % 7) + 1);
            bus_wr(9'(9'h140 + 4*i), 4'hF, wv);
        end
        bus_wr(9'h168, 4'h1, 32'h0000_00F0);
        bus_wr(9'h164, 4'h1, 32'h0000_005A);

        for (int n = 0; n < 64; n++) begin
            set_src_chk("R6 single source level", 64'd1 << n);
            ack_chk("R8 R10 single source vector", 3'((n % 7) + 1));
            ack_chk("R9 other level spurious", 3'(((n + 1) % 7) + 1));
        end
        @(negedge clk);
        check("R8 valid one cycle", {31'd0, ack_valid}, 32'd0);

        set_src_chk("R6 all sources", '1);
        for (int l = 0; l < 8; l++) ack_chk("R8 R9 lowest index wins", 3'(l));

        // R7: disabled field values
        for (int i = 0; i < 8; i++) bus_wr(9'(9'h140 + 4*i), 4'hF, 32'd0);
        bus_wr(9'h140, 4'hF, 32'h0000_FA80);
        set_src_chk("R7 disabled fields", 64'h0000_0000_0000_00FF);
        check("R7 no request", {29'd0, irq_lvl}, 32'd0);
        ack_chk("R7 ack spurious", 3'd1);
        ack_chk("R7 ack level 0", 3'd0);

        // Mixed patterns with random fields, base and sources
        r = 64'hC0FF_EE12_3456_789B;
        for (int t = 0; t < 24; t++) begin
            for (int i = 0; i < 8; i++) begin
                r = lfsr(r); r = lfsr(r); r = lfsr(r);
                bus_wr(9'(9'h140 + 4*i), 4'hF, r[31:0]);
            end
            r = lfsr(r);
            bus_wr(9'h16B, 4'h1, {24'd0, r[7:0]});
            r = lfsr(r); r = lfsr(r);
            set_src_chk("R6 R7 mixed level", r & lfsr(lfsr(lfsr(r))));
            for (int l = 0; l < 8; l++) ack_chk("R8 R9 R10 mixed vector", 3'(l));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule